// File: doc/BRIEF.md
# Loopback and 1:1 Protection Lane Selector

This block joins a parallel user-side port to two serial-side lanes, one working and one standby, both shown here as plain parallel words. Outbound user data is copied to both lanes. Inbound data comes from one lane only, picked by a register bit, and is passed up to the user port. That choice is made after lane alignment, so no alignment logic lives in this block.

Three test paths can be switched in. Two of them turn user transmit data back to the user receive port. The shallow one loops early in the transmit pipe. The deep one loops at the last register before the line outputs, so it costs one extra cycle. In both, the line outputs keep carrying the transmit data. The third path, far-end loopback, sends the received line data back out on the line. It is only allowed while a frame pulse keeps arriving at its nominal period, and it is refused while the pointer-processing stage is marked as bypassed.

Lane choice and loopback changes are held back until the next frame pulse, so no frame is ever split. Until the first pulse after reset has been seen, they apply at once.

Top module: `loopsel_top`

## Requirements
- R1: Whenever far-end loopback is not active, both `lineTxWork` and `lineTxProt` carry `usrTxData` two cycles late, and they are always equal to each other.
- R2: Bit 0 of the control register (address 0) selects the inbound lane: 0 picks `lineRxWork` and 1 picks `lineRxProt`. With no near-end loopback active, `usrRxData` shows the selected lane two cycles late.
- R3: Loopback field value 01 (control bits 2:1) is near-end shallow. `usrRxData` shows `usrTxData` two cycles late, and the line outputs still carry transmit data.
- R4: Loopback field value 10 is near-end deep. `usrRxData` shows `usrTxData` three cycles late, one cycle more than shallow, and the line outputs still carry transmit data.
- R5: Loopback field value 11 is far-end. When it is allowed, both line outputs carry the selected inbound lane two cycles late, and `usrRxData` still shows that lane. At most one loop path is active at a time.
- R6: The period register (address 1) sets the nominal number of cycles between pulses. A pulse spacing within ±2 cycles of it counts as good. After three good spacings in a row, frame-ok (status bit 0) goes to 1. A pulse arriving more than 2 cycles early, or no pulse within nominal+2 cycles, clears frame-ok.
- R7: Far-end loopback is refused while frame-ok is 0, or while the bypass bit (control bit 3) is 1. In that case the datapath behaves as in normal mode and status bit 1 reads 1. The bypass bit takes effect in the cycle after it is written.
- R8: After the first frame pulse since reset, a new lane choice or loopback value becomes active only at the next pulse. Before that first pulse, a write applies in the cycle after it.
- R9: Reading address 0 returns the written control value {bypass, loop[1:0], lane} in bits 3:0. Address 1 returns the period. Address 2 returns status: bit 0 frame-ok, bit 1 far-end refused, bit 2 active lane, bits 4:3 active loop value.
- R10: After reset, control and status read 0, the period reads its default value, and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | PER_W | Register write data |
| regRdata | output | PER_W | Register read data (combinational) |
| framePulse | input | 1 | One-cycle frame pulse |
| usrTxData | input | DATA_W | User transmit word |
| usrRxData | output | DATA_W | User receive word |
| lineTxWork | output | DATA_W | Line output, working lane |
| lineTxProt | output | DATA_W | Line output, standby lane |
| lineRxWork | input | DATA_W | Line input, working lane |
| lineRxProt | input | DATA_W | Line input, standby lane |

## Verification
The latency assertions assume the loop value stays the same for the whole window they look back over, and that the frame pulse is one cycle wide. The bench changes the loop value only through register writes, then waits several cycles before it checks or streams data. It drives the frame pulse as single-cycle strobes placed at exact cycle offsets, so both good and bad spacings land where they were intended.

// File: rtl/loopsel_pkg.sv
package loopsel_pkg;

  typedef enum logic [1:0] {
    LB_NONE     = 2'b00,
    LB_NEAR_IN  = 2'b01,
    LB_NEAR_OUT = 2'b10,
    LB_FAR      = 2'b11
  } lbMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useProt;
    logic nearIn;
    logic nearOut;
    logic farOn;
  } pathCtl_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

endpackage

// File: rtl/loopsel_ctrl.sv
module loopsel_ctrl
  import loopsel_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int DEF_PERIOD = 15625,
  parameter int TOL        = 2,
  parameter int GOOD_NEED  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [PER_W-1:0] regWdata,
  output logic [PER_W-1:0] regRdata,
  input  logic             framePulse,
  output pathCtl_t         pathCtl
);

  localparam int CNT_W  = PER_W + 1;
  localparam int GCNT_W = $clog2(GOOD_NEED + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  TOL_C   = CNT_W'(TOL);
  localparam logic [GCNT_W-1:0] GOOD_C  = GCNT_W'(GOOD_NEED);

  logic             pendSel, actSel, bypassQ, everSeen;
  lbMode_e          pendMode, actMode;
  logic [PER_W-1:0] periodQ;
  logic [CNT_W-1:0] gapCnt, hiLim, loLim;
  logic [GCNT_W-1:0] goodCnt;
  logic             armed, frameOk, farOk, farRefused;
  logic             ctrlWr, perWr, inWindow;

  assign ctrlWr = regWe && (regAddr == ADDR_CTRL);
  assign perWr  = regWe && (regAddr == ADDR_PERIOD);

  // configuration: lane and loop value are framed once a pulse has been seen
  always_ff @(posedge clk) begin
    if (rst) begin
      pendSel  <= 1'b0;
      pendMode <= LB_NONE;
      actSel   <= 1'b0;
      actMode  <= LB_NONE;
      bypassQ  <= 1'b0;
      everSeen <= 1'b0;
      periodQ  <= PER_W'(DEF_PERIOD);
    end else begin
      if (ctrlWr) begin
        pendSel  <= regWdata[0];
        pendMode <= lbMode_e'(regWdata[2:1]);
        bypassQ  <= regWdata[3];
      end
      if (perWr) periodQ <= regWdata;
      if (framePulse) begin
        actSel   <= pendSel;
        actMode  <= pendMode;
        everSeen <= 1'b1;
      end else if (ctrlWr && !everSeen) begin
        actSel  <= regWdata[0];
        actMode <= lbMode_e'(regWdata[2:1]);
      end
    end
  end

  // frame pulse spacing checker
  assign hiLim    = {1'b0, periodQ} + TOL_C;
  assign loLim    = ({1'b0, periodQ} > TOL_C) ? ({1'b0, periodQ} - TOL_C) : '0;
  assign inWindow = (gapCnt >= loLim) && (gapCnt <= hiLim);

  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt  <= '0;
      armed   <= 1'b0;
      goodCnt <= '0;
    end else if (framePulse) begin
      gapCnt <= CNT_W'(1);
      armed  <= 1'b1;
      if (armed) begin
        if (!inWindow)            goodCnt <= '0;
        else if (goodCnt != GOOD_C) goodCnt <= goodCnt + 1'b1;
      end
    end else begin
      if (gapCnt != CNT_MAX) gapCnt <= gapCnt + 1'b1;
      if (armed && (gapCnt > hiLim)) begin
        goodCnt <= '0;
        armed   <= 1'b0;
      end
    end
  end

  assign frameOk    = (goodCnt == GOOD_C);
  assign farOk      = frameOk && !bypassQ;
  assign farRefused = (actMode == LB_FAR) && !farOk;

  assign pathCtl.useProt = actSel;
  assign pathCtl.nearIn  = (actMode == LB_NEAR_IN);
  assign pathCtl.nearOut = (actMode == LB_NEAR_OUT);
  assign pathCtl.farOn   = (actMode == LB_FAR) && farOk;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:   regRdata[3:0] = {bypassQ, pendMode, pendSel};
      ADDR_PERIOD: regRdata      = periodQ;
      ADDR_STATUS: regRdata[4:0] = {actMode, actSel, farRefused, frameOk};
      default:     regRdata      = '0;
    endcase
  end

  AST_FRAMED_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (everSeen && !framePulse) |=> ($stable(actMode) && $stable(actSel))); // R8

  AST_OK_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(frameOk) |-> $past(framePulse)); // R6

  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (armed && !framePulse && (gapCnt > hiLim)) |=> !frameOk); // R6

endmodule

// File: rtl/loopsel_dp.sv
module loopsel_dp
  import loopsel_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pathCtl_t          pathCtl,
  input  logic [DATA_W-1:0] usrTxData,
  output logic [DATA_W-1:0] usrRxData,
  output logic [DATA_W-1:0] lineTxWork,
  output logic [DATA_W-1:0] lineTxProt,
  input  logic [DATA_W-1:0] lineRxWork,
  input  logic [DATA_W-1:0] lineRxProt
);

  localparam int LANES = 2;

  logic [DATA_W-1:0] txA, txNext, rxSel, rxOut;
  logic [DATA_W-1:0] txLane [LANES];
  logic [1:0]        ageCnt;

  assign txNext = pathCtl.farOn ? rxSel : txA;

  always_ff @(posedge clk) begin
    if (rst) begin
      txA   <= '0;
      rxSel <= '0;
      rxOut <= '0;
    end else begin
      txA   <= usrTxData;
      rxSel <= pathCtl.useProt ? lineRxProt : lineRxWork;
      if (pathCtl.nearIn)       rxOut <= txA;
      else if (pathCtl.nearOut) rxOut <= txLane[0];
      else                      rxOut <= rxSel;
    end
  end

  // broadcast: one output register per lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst) txLane[g] <= '0;
      else     txLane[g] <= txNext;
    end
  end

  assign lineTxWork = txLane[0];
  assign lineTxProt = txLane[1];
  assign usrRxData  = rxOut;

  // cycles since reset, for latency assertions only
  always_ff @(posedge clk) begin
    if (rst)                 ageCnt <= '0;
    else if (ageCnt != 2'd3) ageCnt <= ageCnt + 2'd1;
  end

  AST_TX_BROADCAST: assert property (@(posedge clk) disable iff (rst)
    lineTxWork == lineTxProt); // R1

  AST_INNER_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ((ageCnt >= 2'd2) && $past(pathCtl.nearIn)) |-> (usrRxData == $past(usrTxData, 2))); // R3

  AST_OUTER_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ((ageCnt == 2'd3) && $past(pathCtl.nearOut) && $past(pathCtl.nearOut, 2))
      |-> (usrRxData == $past(usrTxData, 3))); // R4

  AST_ONE_LOOP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pathCtl.nearIn, pathCtl.nearOut, pathCtl.farOn})); // R5

endmodule

// File: rtl/loopsel_top.sv
module loopsel_top
  import loopsel_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int PER_W      = 16,
  parameter int DEF_PERIOD = 15625
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [PER_W-1:0]  regWdata,
  output logic [PER_W-1:0]  regRdata,
  input  logic              framePulse,
  input  logic [DATA_W-1:0] usrTxData,
  output logic [DATA_W-1:0] usrRxData,
  output logic [DATA_W-1:0] lineTxWork,
  output logic [DATA_W-1:0] lineTxProt,
  input  logic [DATA_W-1:0] lineRxWork,
  input  logic [DATA_W-1:0] lineRxProt
);

  pathCtl_t pathCtl;

  loopsel_ctrl #(
    .PER_W      (PER_W),
    .DEF_PERIOD (DEF_PERIOD),
    .TOL        (2),
    .GOOD_NEED  (3)
  ) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .framePulse (framePulse),
    .pathCtl    (pathCtl)
  );

  loopsel_dp #(
    .DATA_W (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .pathCtl    (pathCtl),
    .usrTxData  (usrTxData),
    .usrRxData  (usrRxData),
    .lineTxWork (lineTxWork),
    .lineTxProt (lineTxProt),
    .lineRxWork (lineRxWork),
    .lineRxProt (lineRxProt)
  );

endmodule

// File: tb/loopsel_top_tb_top.sv
module loopsel_top_tb_top;

  localparam int DW = 16;
  localparam int PW = 16;
  localparam int DEFP = 15625;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [PW-1:0] regWdata = '0;
  logic [PW-1:0] regRdata;
  logic          framePulse = 1'b0;
  logic [DW-1:0] usrTxData = '0;
  logic [DW-1:0] usrRxData, lineTxWork, lineTxProt;
  logic [DW-1:0] lineRxWork = '0;
  logic [DW-1:0] lineRxProt = '0;

  int  nChecks = 0;
  int  nFails  = 0;
  int  since   = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  loopsel_top #(.DATA_W(DW), .PER_W(PW), .DEF_PERIOD(DEFP)) dut_i (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .framePulse(framePulse),
    .usrTxData(usrTxData), .usrRxData(usrRxData),
    .lineTxWork(lineTxWork), .lineTxProt(lineTxProt),
    .lineRxWork(lineRxWork), .lineRxProt(lineRxProt)
  );

  // {ctrl[3:0], tx, rxWork, rxProt, expUsrRx, expLineTx, expRefused}
  localparam int VN = 7;
  localparam logic [84:0] VEC [VN] = '{
    {4'h0, 16'hA001, 16'hB001, 16'hC001, 16'hB001, 16'hA001, 1'b0},
    {4'h1, 16'hA002, 16'hB002, 16'hC002, 16'hC002, 16'hA002, 1'b0},
    {4'h2, 16'hA003, 16'hB003, 16'hC003, 16'hA003, 16'hA003, 1'b0},
    {4'h4, 16'hA004, 16'hB004, 16'hC004, 16'hA004, 16'hA004, 1'b0},
    {4'h6, 16'hA005, 16'hB005, 16'hC005, 16'hB005, 16'hA005, 1'b1},
    {4'h7, 16'hA006, 16'hB006, 16'hC006, 16'hC006, 16'hA006, 1'b1},
    {4'h3, 16'hA007, 16'hB007, 16'hC007, 16'hA007, 16'hA007, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    since++;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [PW-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [PW-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulseNow();
    framePulse = 1'b1;
    tick();
    framePulse = 1'b0;
    since = 1;
  endtask

  task automatic pulseWait(input int d);
    pulseNow();
    while (since < d) tick();
  endtask

  localparam logic [DW-1:0] T = 16'h5A5A, W = 16'h1234, P = 16'hABCD;

  initial begin
    logic [PW-1:0] rd;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R10 reset state
    regRead(2'd0, rd); chk("R10 ctrl", 32'(rd), 32'h0);
    regRead(2'd2, rd); chk("R10 status", 32'(rd), 32'h0);
    regRead(2'd1, rd); chk("R10 period", 32'(rd), 32'(DEFP));
    chk("R10 usrRx", 32'(usrRxData), 32'h0);
    chk("R10 lineTx", 32'({lineTxWork, lineTxProt}), 32'h0);

    // table walk, no frame pulses yet: changes apply at once (R8)
    for (int i = 0; i < VN; i++) begin
      logic [84:0] v;
      v = VEC[i];
      usrTxData = v[80:65]; lineRxWork = v[64:49]; lineRxProt = v[48:33];
      regWrite(2'd0, PW'(v[84:81]));
      repeat (4) tick();
      chk("R2/R3/R4 usrRx", 32'(usrRxData), 32'(v[32:17]));
      chk("R1 lineTxWork", 32'(lineTxWork), 32'(v[16:1]));
      chk("R1 lineTxProt", 32'(lineTxProt), 32'(v[16:1]));
      regRead(2'd2, rd);
      chk("R7 refused bit", 32'(rd[1]), 32'(v[0]));
    end

    // R3 shallow latency 2, R4 deep latency 3
    regWrite(2'd0, 16'h2);
    repeat (4) tick();
    for (int j = 0; j < 10; j++) begin
      if (j >= 2) chk("R3 latency", 32'(usrRxData), 32'(16'h100 + j - 2));
      if (j >= 2) chk("R3 line active", 32'(lineTxWork), 32'(16'h100 + j - 2));
      usrTxData = 16'(16'h100 + j);
      tick();
    end
    regWrite(2'd0, 16'h4);
    repeat (4) tick();
    for (int j = 0; j < 10; j++) begin
      if (j >= 3) chk("R4 latency", 32'(usrRxData), 32'(16'h200 + j - 3));
      if (j >= 2) chk("R4 line active", 32'(lineTxProt), 32'(16'h200 + j - 2));
      usrTxData = 16'(16'h200 + j);
      tick();
    end

    // frame checker and far-end loopback
    usrTxData = T; lineRxWork = W; lineRxProt = P;
    regWrite(2'd0, 16'h0);
    regWrite(2'd1, 16'd20);
    regRead(2'd1, rd); chk("R9 period readback", 32'(rd), 32'd20);
    repeat (3) pulseWait(20);
    regRead(2'd2, rd); chk("R6 not ok after two spacings", 32'(rd[0]), 32'h0);
    pulseNow();
    regRead(2'd2, rd); chk("R6 ok after three spacings", 32'(rd), 32'h1);

    regWrite(2'd0, 16'h6);
    regRead(2'd0, rd); chk("R9 ctrl readback", 32'(rd), 32'h6);
    repeat (2) tick();
    chk("R8 held until pulse", 32'(lineTxWork), 32'(T));
    regRead(2'd2, rd); chk("R8 active mode held", 32'(rd[4:3]), 32'h0);
    while (since < 20) tick();
    pulseNow();
    repeat (3) tick();
    chk("R5 far lineTxWork", 32'(lineTxWork), 32'(W));
    chk("R5 far lineTxProt", 32'(lineTxProt), 32'(W));
    chk("R5 far usrRx", 32'(usrRxData), 32'(W));
    regRead(2'd2, rd); chk("R9 status far", 32'(rd), 32'h19);

    regWrite(2'd0, 16'hE);
    repeat (3) tick();
    chk("R7 bypass refuses", 32'(lineTxWork), 32'(T));
    regRead(2'd2, rd); chk("R7 bypass status", 32'(rd), 32'h1B);
    regWrite(2'd0, 16'h6);
    repeat (3) tick();
    chk("R7 bypass cleared", 32'(lineTxWork), 32'(W));

    // early pulse
    while (since < 10) tick();
    pulseNow();
    regRead(2'd2, rd); chk("R6 early pulse clears", 32'(rd[0]), 32'h0);
    repeat (3) tick();
    chk("R7 far dropped", 32'(lineTxWork), 32'(T));

    // recover, then missing pulse
    while (since < 20) tick();
    repeat (3) pulseWait(20);
    pulseNow();
    regRead(2'd2, rd); chk("R6 recovered", 32'(rd[0]), 32'h1);
    repeat (3) tick();
    chk("R5 far again", 32'(lineTxProt), 32'(W));
    while (since < 30) tick();
    regRead(2'd2, rd); chk("R6 missing pulse clears", 32'(rd[0]), 32'h0);
    chk("R7 far dropped on timeout", 32'(lineTxWork), 32'(T));

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule